// File: doc/BRIEF.md
# Count/Compare Timer with Interrupt

This block is a 32-bit count register paired with a compare register, of the kind that sits beside a processor core as a system timer. The count advances by one on every cycle that the tick-enable input is high, unless the freeze input is set. When an increment brings the count to the compare value, the block raises a timer interrupt and holds it until software acknowledges it by writing a new compare value.

Software reaches both registers through a simple write port: one strobe per register and a shared data bus. A write to the count register replaces only the count. A write to the compare register replaces the compare value and also serves as the interrupt acknowledge. A second flag, the timer status bit, follows the interrupt only when the 3-bit architecture-release input holds the value 1. For any other release value the flag keeps whatever value it had.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset the count reads 1, the compare reads 0, and both the interrupt and the status bit are 0.
- R2: On a clock edge where tick_en is 1, the freeze input is 0 and no count write is present, the count increases by one. Without tick_en it keeps its value.
- R3: While count_freeze is 1, tick_en has no effect on the count and no match can be raised.
- R4: When an increment makes the count equal to the compare value, timer_irq goes to 1 on that same edge. It stays at 1 through later ticks and count writes until a compare write.
- R5: A compare write loads wr_data into the compare register and drives timer_irq to 0 on the edge that performs the write.
- R6: When arch_rel equals 3'd1, a match sets timer_stat and a compare write clears it. For any other arch_rel value, timer_stat keeps its value through matches and compare writes.
- R7: A count write loads wr_data into the count on that edge. It takes priority over a tick in the same cycle, leaves the compare value alone and does not change timer_irq.
- R8: A match is raised only by an increment. A count write that makes the count equal to the compare value raises nothing, and the next tick moves the count past the compare value with no interrupt.
- R9: The count wraps from 32'hFFFFFFFF to 0 with no side effect. It matches on the wrap only if the compare value is 0.
- R10: When a compare write and a match fall on the same edge, the write wins: timer_irq ends at 0 and, when arch_rel is 1, timer_stat ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance the count by one on this edge |
| count_freeze | input | 1 | When 1, the count is held and no match can occur |
| count_wr | input | 1 | Write strobe for the count register |
| compare_wr | input | 1 | Write strobe for the compare register; also acknowledges the interrupt |
| wr_data | input | 32 | Data for either write strobe |
| arch_rel | input | 3 | Architecture release; the value 1 enables the status bit |
| count_q | output | 32 | Current count |
| compare_q | output | 32 | Current compare value |
| timer_irq | output | 1 | Timer interrupt, held until a compare write |
| timer_stat | output | 1 | Timer status bit, updated only when arch_rel is 1 |

## Verification
The match logic is tested by ticking toward the compare value from a few counts below it, with idle cycles mixed in. This separates a match on the reaching increment from an early or late one. Further tests place the count equal to the compare value by a write, and tick across the 32-bit wrap with the compare value both nonzero and zero. These tell a true equality-on-increment detector apart from one that compares the stored count or ignores the wrap. Collision cycles (count write with a tick, compare write with a match) and freeze cycles show which source wins. The status bit is run under release values 1, 2 and 0, which separates gated updates from ungated ones.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int unsigned CNT_W_DEF    = 32;
    localparam int unsigned REL_W_DEF    = 3;
    localparam int unsigned STAT_REL_DEF = 1;
    localparam int unsigned COUNT_RST    = 1;

    // Per-cycle control gathered from the strobes
    typedef struct packed {
        logic tick;
        logic freeze;
        logic count_we;
        logic compare_we;
    } tmr_ctl_t;

    // Interrupt-side state
    typedef struct packed {
        logic irq;
        logic stat;
    } tmr_flags_t;

    function automatic logic counts_now(input tmr_ctl_t c);
        return c.tick && !c.freeze && !c.count_we;
    endfunction

endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W   = CNT_W_DEF,
    parameter int unsigned RST_VAL = COUNT_RST
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             match
);
    logic             adv;
    logic [CNT_W-1:0] count_inc;

    always_comb begin
        adv       = counts_now(ctl);
        count_inc = count + CNT_W'(1);
        match     = adv && (count_inc == cmp_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CNT_W'(RST_VAL);
        end else if (ctl.count_we) begin
            count <= wdata;
        end else if (adv) begin
            count <= count_inc;
        end
    end
endmodule

// File: rtl/cmp_timer_compare.sv
module cmp_timer_compare
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cmp_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val <= '0;
        end else if (ctl.compare_we) begin
            cmp_val <= wdata;
        end
    end
endmodule

// File: rtl/cmp_timer_flags.sv
module cmp_timer_flags
    import cmp_timer_pkg::*;
#(
    parameter int unsigned REL_W    = REL_W_DEF,
    parameter int unsigned STAT_REL = STAT_REL_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_ctl_t         ctl,
    input  logic             match,
    input  logic [REL_W-1:0] rel,
    output tmr_flags_t       flags
);
    localparam logic [REL_W-1:0] REL_SEL = REL_W'(STAT_REL);

    tmr_flags_t flags_nxt;
    logic       stat_live;

    always_comb begin
        stat_live = (rel == REL_SEL);
        flags_nxt = flags;
        // acknowledge takes precedence over a same-cycle match
        if (ctl.compare_we) begin
            flags_nxt.irq = 1'b0;
            if (stat_live) flags_nxt.stat = 1'b0;
        end else if (match) begin
            flags_nxt.irq = 1'b1;
            if (stat_live) flags_nxt.stat = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int unsigned CNT_W    = CNT_W_DEF,
    parameter int unsigned REL_W    = REL_W_DEF,
    parameter int unsigned STAT_REL = STAT_REL_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             count_freeze,
    input  logic             count_wr,
    input  logic             compare_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [REL_W-1:0] arch_rel,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] compare_q,
    output logic             timer_irq,
    output logic             timer_stat
);
    tmr_ctl_t   ctl;
    tmr_flags_t flags;
    logic       match;

    always_comb begin
        ctl.tick       = tick_en;
        ctl.freeze     = count_freeze;
        ctl.count_we   = count_wr;
        ctl.compare_we = compare_wr;
    end

    cmp_timer_counter #(.CNT_W(CNT_W), .RST_VAL(COUNT_RST)) u_count (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wdata   (wr_data),
        .cmp_val (compare_q),
        .count   (count_q),
        .match   (match)
    );

    cmp_timer_compare #(.CNT_W(CNT_W)) u_compare (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wdata   (wr_data),
        .cmp_val (compare_q)
    );

    cmp_timer_flags #(.REL_W(REL_W), .STAT_REL(STAT_REL)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .match (match),
        .rel   (arch_rel),
        .flags (flags)
    );

    assign timer_irq  = flags.irq;
    assign timer_stat = flags.stat;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned REL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             count_freeze,
    input logic             count_wr,
    input logic             compare_wr,
    input logic [CNT_W-1:0] wr_data,
    input logic [REL_W-1:0] arch_rel,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] compare_q,
    input logic             timer_irq,
    input logic             timer_stat
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !count_freeze && !count_wr) |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R3
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count_freeze && !count_wr) |=> $stable(count_q));

    // R4
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (timer_irq && !compare_wr) |=> timer_irq);

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        compare_wr |=> (!timer_irq && compare_q == $past(wr_data)));

    // R6
    stat_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (arch_rel != REL_W'(1)) |=> $stable(timer_stat));

    // R7
    count_write_chk: assert property (@(posedge clk) disable iff (rst)
        (count_wr && !compare_wr) |=> (count_q == $past(wr_data) && $stable(timer_irq) && $stable(compare_q)));

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timer_irq) |-> (count_q == compare_q));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .count_freeze (count_freeze),
    .count_wr     (count_wr),
    .compare_wr   (compare_wr),
    .wr_data      (wr_data),
    .arch_rel     (arch_rel),
    .count_q      (count_q),
    .compare_q    (compare_q),
    .timer_irq    (timer_irq),
    .timer_stat   (timer_stat)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        count_freeze = 1'b0;
    logic        count_wr = 1'b0;
    logic        compare_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  arch_rel = 3'd1;
    logic [31:0] count_q;
    logic [31:0] compare_q;
    logic        timer_irq;
    logic        timer_stat;

    int tests_run = 0;
    int tests_bad = 0;

    always #2.5 clk = ~clk;

    cmp_timer uut (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .count_freeze (count_freeze),
        .count_wr     (count_wr),
        .compare_wr   (compare_wr),
        .wr_data      (wr_data),
        .arch_rel     (arch_rel),
        .count_q      (count_q),
        .compare_q    (compare_q),
        .timer_irq    (timer_irq),
        .timer_stat   (timer_stat)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one cycle from a negedge; returns at the next negedge with outputs settled
    task automatic step(input logic t, input logic cw, input logic pw, input logic [31:0] d);
        tick_en    = t;
        count_wr   = cw;
        compare_wr = pw;
        wr_data    = d;
        @(negedge clk);
        tick_en    = 1'b0;
        count_wr   = 1'b0;
        compare_wr = 1'b0;
    endtask

    task automatic set_cmp(input logic [31:0] d);
        step(1'b0, 1'b0, 1'b1, d);
    endtask

    task automatic set_cnt(input logic [31:0] d);
        step(1'b0, 1'b1, 1'b0, d);
    endtask

    task automatic tick();
        step(1'b1, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1", "count", count_q, 32'd1);
        chk("R1", "compare", compare_q, 32'd0);
        chk("R1", "irq", {31'd0, timer_irq}, 32'd0);
        chk("R1", "stat", {31'd0, timer_stat}, 32'd0);
        tick(); tick(); tick();
        chk("R2", "count after 3 ticks", count_q, 32'd4);
        step(1'b0, 1'b0, 1'b0, 32'h0);
        chk("R2", "count idle", count_q, 32'd4);
        chk("R9", "no match from reset values", {31'd0, timer_irq}, 32'd0);
    endtask

    task automatic t_match();
        arch_rel = 3'd1;
        set_cmp(32'd10);
        set_cnt(32'd7);
        tick();
        chk("R4", "irq at 8", {31'd0, timer_irq}, 32'd0);
        step(1'b0, 1'b0, 1'b0, 32'h0);
        tick();
        chk("R4", "irq at 9", {31'd0, timer_irq}, 32'd0);
        tick();
        chk("R4", "count at match", count_q, 32'd10);
        chk("R4", "irq at match", {31'd0, timer_irq}, 32'd1);
        chk("R6", "stat set rel1", {31'd0, timer_stat}, 32'd1);
        tick();
        chk("R4", "irq sticky", {31'd0, timer_irq}, 32'd1);
    endtask

    task automatic t_ack();
        set_cmp(32'd100);
        chk("R5", "compare loaded", compare_q, 32'd100);
        chk("R5", "irq cleared", {31'd0, timer_irq}, 32'd0);
        chk("R6", "stat cleared rel1", {31'd0, timer_stat}, 32'd0);
    endtask

    task automatic t_freeze();
        set_cnt(32'd99);
        count_freeze = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        chk("R3", "count frozen", count_q, 32'd99);
        chk("R3", "no match frozen", {31'd0, timer_irq}, 32'd0);
        count_freeze = 1'b0;
        tick();
        chk("R3", "count after release", count_q, 32'd100);
        chk("R4", "match after release", {31'd0, timer_irq}, 32'd1);
    endtask

    task automatic t_count_write();
        set_cnt(32'd5);
        chk("R7", "count written", count_q, 32'd5);
        chk("R7", "compare kept", compare_q, 32'd100);
        chk("R7", "irq kept", {31'd0, timer_irq}, 32'd1);
        step(1'b1, 1'b1, 1'b0, 32'd40);
        chk("R7", "write beats tick", count_q, 32'd40);
    endtask

    task automatic t_equal_write();
        set_cmp(32'd50);
        set_cnt(32'd50);
        chk("R8", "no match from write", {31'd0, timer_irq}, 32'd0);
        tick();
        chk("R8", "count past compare", count_q, 32'd51);
        chk("R8", "no match passing", {31'd0, timer_irq}, 32'd0);
    endtask

    task automatic t_wrap();
        set_cmp(32'd3);
        set_cnt(32'hFFFF_FFFF);
        tick();
        chk("R9", "wrap to zero", count_q, 32'd0);
        chk("R9", "no irq on wrap", {31'd0, timer_irq}, 32'd0);
        set_cmp(32'd0);
        set_cnt(32'hFFFF_FFFE);
        tick();
        chk("R9", "irq before wrap", {31'd0, timer_irq}, 32'd0);
        tick();
        chk("R9", "match at zero", {31'd0, timer_irq}, 32'd1);
    endtask

    task automatic t_collide();
        set_cmp(32'd20);
        set_cnt(32'd18);
        tick();
        step(1'b1, 1'b0, 1'b1, 32'd500);
        chk("R10", "count advanced", count_q, 32'd20);
        chk("R10", "compare written", compare_q, 32'd500);
        chk("R10", "irq stays clear", {31'd0, timer_irq}, 32'd0);
        chk("R10", "stat stays clear", {31'd0, timer_stat}, 32'd0);
    endtask

    task automatic t_release();
        arch_rel = 3'd2;
        set_cmp(32'd30);
        set_cnt(32'd29);
        tick();
        chk("R6", "irq with rel2", {31'd0, timer_irq}, 32'd1);
        chk("R6", "stat untouched rel2", {31'd0, timer_stat}, 32'd0);
        arch_rel = 3'd1;
        set_cmp(32'd31);
        set_cnt(32'd30);
        tick();
        chk("R6", "stat set rel1", {31'd0, timer_stat}, 32'd1);
        arch_rel = 3'd0;
        set_cmp(32'd60);
        chk("R6", "irq cleared rel0", {31'd0, timer_irq}, 32'd0);
        chk("R6", "stat kept rel0", {31'd0, timer_stat}, 32'd1);
        arch_rel = 3'd1;
    endtask

    initial begin
        #50000;
        tests_run++;
        tests_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_match();
        t_ack();
        t_freeze();
        t_count_write();
        t_equal_write();
        t_wrap();
        t_collide();
        t_release();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_bad);
        $finish;
    end
endmodule